// File: doc/BRIEF.md
# Live-Insertion Transaction Gate

This block sits beside the command register of a two-sided bus bridge and decides, cycle by cycle, which transactions the bridge may take on while a hot-plug control pin is in use. Software writes the I/O-space, memory-space and bus-master enable bits through configuration writes, and the block keeps them. It also takes a live-insertion mode bit, the output-drive setting of the control pin and the pin itself. When the mode is on, the pin is set to input-only and the pin reads 1, the effective enables given to the target and master logic are forced to 0. Readback still shows what software wrote. When the pin drops, the enables come back at once.

While the bridge is gated, it refuses I/O and memory requests on both the upstream and the downstream side. Configuration requests are always accepted. Posted writes and delayed requests that were queued before gating still get permission to be mastered out, so the queues drain. Delayed completions are held back and are not returned to the requester. Once gating is in force and both outbound queues report zero entries, a halted flag rises. Software can then assert the downstream reset. The queues and the bus engines themselves are outside this block. Only their occupancy counts and a completion-ready flag come in.

The pin is asynchronous. It passes through a two-flop synchronizer before it has any effect.

Top module: `hotplug_txn_gate`

## Requirements
- R1: After reset, the command readback, all three effective enables, `gated`, `halted` and every issue and accept output are 0.
- R2: A cycle with `cmdWe`=1 stores `cmdWdata` at the rising edge. Bit 0 is the I/O enable, bit 1 the memory enable and bit 2 the master enable. The stored value appears on `cmdRdata` after that edge. Cycles with `cmdWe`=0 leave it unchanged.
- R3: `gated` is 1 exactly when `liveModeEn`=1, `pinDriveEn`=0 (pin set to input-only) and the synchronized pin is 1. In every other mode and drive combination it is 0, whatever the pin does.
- R4: While `gated`=1, `effIoEn`, `effMemEn` and `effMasterEn` are all 0. While `gated`=0, they equal stored bits 0, 1 and 2.
- R5: Gating never alters `cmdRdata`. Readback shows the last written value whether gated or not.
- R6: A change on `pinIn` reaches `gated` after exactly two rising clock edges and not after one. A falling pin releases the enables with the same latency.
- R7: For each port p (0 = upstream, 1 = downstream), `reqAccept[p]` depends on `reqType[p]` as follows. Code 00 (idle) gives 0. Code 01 (configuration) gives 1 even while gated. Code 10 (I/O) follows `effIoEn`. Code 11 (memory) follows `effMemEn`.
- R8: `postedIssue` is 1 when stored master enable is 1 and `postedCnt` is non-zero. `dlyReqIssue` is 1 when stored master enable is 1 and `dlyReqCnt` is non-zero. Both hold whether or not the bridge is gated.
- R9: `dcReturn` equals `dcReady` while not gated and is 0 while gated.
- R10: `halted` is 1 exactly when `gated`=1 and both `postedCnt` and `dlyReqCnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWe | input | 1 | Configuration write strobe for the command enables |
| cmdWdata | input | 3 | Enable bits to write (0 I/O, 1 memory, 2 master) |
| cmdRdata | output | 3 | Readback of the stored enable bits |
| liveModeEn | input | 1 | Live-insertion mode bit |
| pinDriveEn | input | 1 | Control pin output drive, 0 = input-only |
| pinIn | input | 1 | Asynchronous control pin value |
| postedCnt | input | CNT_W | Posted-write queue occupancy |
| dlyReqCnt | input | CNT_W | Delayed-request queue occupancy |
| dcReady | input | 1 | A delayed completion is ready to return |
| reqType | input | NUM_PORTS x 2 | Incoming target request class per port |
| reqAccept | output | NUM_PORTS | Target acceptance per port |
| effIoEn | output | 1 | Effective I/O enable |
| effMemEn | output | 1 | Effective memory enable |
| effMasterEn | output | 1 | Effective master enable |
| postedIssue | output | 1 | Permission to master a queued posted write |
| dlyReqIssue | output | 1 | Permission to master a queued delayed request |
| dcReturn | output | 1 | Permission to return a delayed completion |
| gated | output | 1 | Gating in force |
| halted | output | 1 | Gated and both queues empty |

## Verification
A stuck or wrong synchronizer stage shows up at `gated` and the effective enables two edges after a pin change. The bench samples exactly one edge and two edges after each change, so both an early and a late response are seen. A corrupted command register shows up on `cmdRdata` in the cycle after the write, and again in the effective enables once gating lifts. The sweep crosses every stored value with every mode, drive and pin combination. A mistake in the gate term therefore reaches the accept outputs of both ports, `dcReturn` and `halted` within the same settled cycle.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
  localparam int CMD_W       = 3;
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  localparam int CMD_MST_BIT = 2;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_CFG  = 2'b01,
    REQ_IO   = 2'b10,
    REQ_MEM  = 2'b11
  } req_kind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic gateOn;
    logic postedPend;
    logic dlyPend;
  } hpg_strobe_t;
endpackage

// File: rtl/hpg_ctrl.sv
module hpg_ctrl
  import hpg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             liveModeEn,
  input  logic             pinDriveEn,
  input  logic             pinIn,
  input  logic [CNT_W-1:0] postedCnt,
  input  logic [CNT_W-1:0] dlyReqCnt,
  output hpg_strobe_t      strobe,
  output logic             gated,
  output logic             halted
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  // Synchronizer chain, one flop per stage
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  logic gateArmed;
  logic queuesEmpty;

  always_comb begin
    gateArmed         = liveModeEn && !pinDriveEn;
    queuesEmpty       = (postedCnt == '0) && (dlyReqCnt == '0);
    strobe.gateOn     = gateArmed && syncQ[LAST];
    strobe.postedPend = (postedCnt != '0);
    strobe.dlyPend    = (dlyReqCnt != '0);
    gated             = strobe.gateOn;
    halted            = strobe.gateOn && queuesEmpty;
  end
endmodule

// File: rtl/hpg_datapath.sv
module hpg_datapath
  import hpg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdWe,
  input  logic [CMD_W-1:0]          cmdWdata,
  output logic [CMD_W-1:0]          cmdRdata,
  input  hpg_strobe_t               strobe,
  input  logic                      dcReady,
  input  logic [NUM_PORTS-1:0][1:0] reqType,
  output logic [NUM_PORTS-1:0]      reqAccept,
  output logic                      effIoEn,
  output logic                      effMemEn,
  output logic                      effMasterEn,
  output logic                      postedIssue,
  output logic                      dlyReqIssue,
  output logic                      dcReturn
);
  logic [CMD_W-1:0] cmdQ;
  logic [CMD_W-1:0] cmdEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cmdQ <= '0;
    else if (cmdWe) cmdQ <= cmdWdata;
  end

  always_comb begin
    cmdRdata    = cmdQ;
    cmdEff      = strobe.gateOn ? '0 : cmdQ;
    effIoEn     = cmdEff[CMD_IO_BIT];
    effMemEn    = cmdEff[CMD_MEM_BIT];
    effMasterEn = cmdEff[CMD_MST_BIT];
    // Queued work drains on the written master enable, not the masked one
    postedIssue = cmdQ[CMD_MST_BIT] && strobe.postedPend;
    dlyReqIssue = cmdQ[CMD_MST_BIT] && strobe.dlyPend;
    dcReturn    = dcReady && !strobe.gateOn;
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      req_kind_t kind;
      always_comb begin
        kind = req_kind_t'(reqType[p]);
        unique case (kind)
          REQ_CFG: reqAccept[p] = 1'b1;
          REQ_IO:  reqAccept[p] = cmdEff[CMD_IO_BIT];
          REQ_MEM: reqAccept[p] = cmdEff[CMD_MEM_BIT];
          default: reqAccept[p] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/hotplug_txn_gate.sv
module hotplug_txn_gate
  import hpg_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdWe,
  input  logic [2:0]                cmdWdata,
  output logic [2:0]                cmdRdata,
  input  logic                      liveModeEn,
  input  logic                      pinDriveEn,
  input  logic                      pinIn,
  input  logic [CNT_W-1:0]          postedCnt,
  input  logic [CNT_W-1:0]          dlyReqCnt,
  input  logic                      dcReady,
  input  logic [NUM_PORTS-1:0][1:0] reqType,
  output logic [NUM_PORTS-1:0]      reqAccept,
  output logic                      effIoEn,
  output logic                      effMemEn,
  output logic                      effMasterEn,
  output logic                      postedIssue,
  output logic                      dlyReqIssue,
  output logic                      dcReturn,
  output logic                      gated,
  output logic                      halted
);
  hpg_strobe_t strobe;

  hpg_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .liveModeEn(liveModeEn), .pinDriveEn(pinDriveEn),
    .pinIn(pinIn), .postedCnt(postedCnt), .dlyReqCnt(dlyReqCnt),
    .strobe(strobe), .gated(gated), .halted(halted)
  );

  hpg_datapath #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWdata(cmdWdata),
    .cmdRdata(cmdRdata), .strobe(strobe), .dcReady(dcReady),
    .reqType(reqType), .reqAccept(reqAccept), .effIoEn(effIoEn),
    .effMemEn(effMemEn), .effMasterEn(effMasterEn),
    .postedIssue(postedIssue), .dlyReqIssue(dlyReqIssue), .dcReturn(dcReturn)
  );
endmodule

// File: rtl/hpg_checker.sv
module hpg_checker #(
  parameter int NUM_PORTS = 2,
  parameter int CNT_W     = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      cmdWe,
  input logic [2:0]                cmdRdata,
  input logic                      pinIn,
  input logic [CNT_W-1:0]          postedCnt,
  input logic [CNT_W-1:0]          dlyReqCnt,
  input logic [NUM_PORTS-1:0][1:0] reqType,
  input logic [NUM_PORTS-1:0]      reqAccept,
  input logic                      effIoEn,
  input logic                      effMemEn,
  input logic                      effMasterEn,
  input logic                      dcReturn,
  input logic                      gated,
  input logic                      halted
);
  p_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    gated |-> (!effIoEn && !effMemEn && !effMasterEn));

  p_readback_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWe |=> $stable(cmdRdata));

  p_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    gated |-> $past(pinIn, 2));

  p_dc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    gated |-> !dcReturn);

  p_halt_r10: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (gated && postedCnt == '0 && dlyReqCnt == '0));

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_chk
      p_cfg_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
        (reqType[p] == 2'b01) |-> reqAccept[p]);
      p_gated_refuse_r7: assert property (@(posedge clk) disable iff (!rstN)
        (gated && reqType[p][1]) |-> !reqAccept[p]);
    end
  endgenerate
endmodule

bind hotplug_txn_gate hpg_checker #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdRdata(cmdRdata), .pinIn(pinIn),
  .postedCnt(postedCnt), .dlyReqCnt(dlyReqCnt), .reqType(reqType),
  .reqAccept(reqAccept), .effIoEn(effIoEn), .effMemEn(effMemEn),
  .effMasterEn(effMasterEn), .dcReturn(dcReturn), .gated(gated),
  .halted(halted)
);

// File: tb/tb_hotplug_txn_gate.sv
module tb_hotplug_txn_gate;
  localparam int PERIOD = 10;
  localparam int NP     = 2;
  localparam int CW     = 4;

  logic                clk = 0;
  logic                rstN = 0;
  logic                cmdWe = 0;
  logic [2:0]          cmdWdata = 0;
  logic [2:0]          cmdRdata;
  logic                liveModeEn = 0, pinDriveEn = 0, pinIn = 0, dcReady = 0;
  logic [CW-1:0]       postedCnt = 0, dlyReqCnt = 0;
  logic [NP-1:0][1:0]  reqType = '0;
  logic [NP-1:0]       reqAccept;
  logic effIoEn, effMemEn, effMasterEn, postedIssue, dlyReqIssue, dcReturn, gated, halted;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  hotplug_txn_gate #(.NUM_PORTS(NP), .CNT_W(CW)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance to next negedge plus settle time
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic writeCmd(input logic [2:0] v);
    cmdWe = 1; cmdWdata = v;
    step();
    cmdWe = 0; cmdWdata = 3'b000;
  endtask

  task automatic checkAll(input logic [2:0] cmd, input bit g);
    int acc;
    chk("R3 gated", gated, g);
    chk("R5 readback", cmdRdata, cmd);
    chk("R4 io", effIoEn, g ? 0 : cmd[0]);
    chk("R4 mem", effMemEn, g ? 0 : cmd[1]);
    chk("R4 master", effMasterEn, g ? 0 : cmd[2]);
    for (int t = 0; t < 4; t++) begin
      reqType = {2'(t), 2'(3 - t)};
      #1;
      for (int p = 0; p < NP; p++) begin
        int k = (p == 1) ? t : 3 - t;
        case (k)
          1: acc = 1;
          2: acc = g ? 0 : cmd[0];
          3: acc = g ? 0 : cmd[1];
          default: acc = 0;
        endcase
        chk($sformatf("R7 port%0d type%0d", p, k), reqAccept[p], acc);
      end
    end
    reqType = '0;
    for (int d = 0; d < 2; d++) begin
      dcReady = d[0];
      #1;
      chk("R9 dcReturn", dcReturn, g ? 0 : d);
    end
    dcReady = 0;
    for (int pc = 0; pc < 3; pc++) begin
      for (int dc = 0; dc < 2; dc++) begin
        postedCnt = (pc == 0) ? 0 : (pc == 1) ? 1 : 15;
        dlyReqCnt = (dc == 0) ? 0 : 3;
        #1;
        chk("R8 postedIssue", postedIssue, (cmd[2] && pc != 0) ? 1 : 0);
        chk("R8 dlyReqIssue", dlyReqIssue, (cmd[2] && dc != 0) ? 1 : 0);
        chk("R10 halted", halted, (g && pc == 0 && dc == 0) ? 1 : 0);
      end
    end
    postedCnt = 0; dlyReqCnt = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    pinIn = 1; liveModeEn = 1; cmdWdata = 3'b111;
    step(); step();
    chk("R1 readback", cmdRdata, 0);
    chk("R1 effIo", effIoEn, 0);
    chk("R1 effMem", effMemEn, 0);
    chk("R1 effMaster", effMasterEn, 0);
    chk("R1 gated", gated, 0);
    chk("R1 halted", halted, 0);
    chk("R1 accept", reqAccept, 0);
    chk("R1 issue", {postedIssue, dlyReqIssue, dcReturn}, 0);
    pinIn = 0; liveModeEn = 0; cmdWdata = 0;
    rstN = 1;
    step();

    // R2 write then hold
    cmdWdata = 3'b101;
    step();
    chk("R2 no write without strobe", cmdRdata, 0);
    writeCmd(3'b101);
    chk("R2 write visible", cmdRdata, 5);
    step();
    chk("R2 held", cmdRdata, 5);

    // R3/R4/R5/R7/R8/R9/R10 sweep
    for (int c = 0; c < 8; c++) begin
      writeCmd(3'(c));
      for (int m = 0; m < 8; m++) begin
        liveModeEn = m[2]; pinDriveEn = m[1]; pinIn = m[0];
        step(); step();
        checkAll(3'(c), (m == 5));
      end
    end

    // R6 latency, rising and falling
    writeCmd(3'b111);
    liveModeEn = 1; pinDriveEn = 0; pinIn = 0;
    step(); step();
    pinIn = 1;
    step();
    chk("R6 one edge no gate", gated, 0);
    chk("R6 one edge io still on", effIoEn, 1);
    step();
    chk("R6 two edges gated", gated, 1);
    chk("R6 two edges master off", effMasterEn, 0);
    pinIn = 0;
    step();
    chk("R6 one edge still gated", gated, 1);
    step();
    chk("R6 release", gated, 0);
    chk("R6 release mem back", effMemEn, 1);

    // R5 write during gating keeps readback, returns after release
    pinIn = 1;
    step(); step();
    writeCmd(3'b010);
    chk("R5 write while gated", cmdRdata, 2);
    chk("R4 mem masked", effMemEn, 0);
    pinIn = 0;
    step(); step();
    chk("R4 mem restored", effMemEn, 1);
    chk("R4 io restored", effIoEn, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule